// File: doc/BRIEF.md
# Three-Section Frequency Replacement Cache Controller

This block keeps the replacement state for a small cache of classification rules. The cache is one ordered list of slots split into a NEW section, a MID section and an OLD section. Every resident rule id carries a saturating reference count. Each access gives a rule id and a hit/miss flag from the external matcher. On each access the block reorders the slots, updates counts and, when the cache is full and a rule must be inserted, picks an OLD-section rule to evict. It does not store rule data and does no matching.

On a miss, the new id enters the head of NEW. Every entry ahead of the freed slot moves one place toward OLD, so the NEW tail drops into MID and the MID tail drops into OLD. Counts only grow for rules that prove themselves after they have aged out of NEW. Eviction takes the lowest count in OLD, not the oldest entry. A build parameter removes the MID section. In that variant NEW spills straight into OLD, and hits in OLD raise the count in place.

All slot contents are exposed flat on the ports, so a checker or a host model can follow the ordering cycle by cycle. Updates take effect at the clock edge that samples the access.

Top module: `freq_rule_cache`

## Requirements
- R1: After reset every slot is empty (`slotValid` all zero) and `victimValid` is low.
- R2: An access with `accValid`=1 and `accHit`=0 puts `accId` in slot 0 (NEW head) with count 1. Every entry from slot 0 up to the freed slot moves one slot higher. Slots are numbered NEW first, then MID, then OLD, with the OLD tail at the highest index. Slot i's id is at `slotIds[i*ID_W +: ID_W]` and its count is at `slotCnts[i*CNT_W +: CNT_W]`.
- R3: While the cache is not full, an insertion takes the first empty slot and reports no victim. Valid slots always form a contiguous run starting at slot 0.
- R4: An insertion into a full cache evicts the OLD-section entry with the smallest count. Ties go to the entry closest to the OLD tail. `victimValid` pulses high with the evicted id on `victimId` in the cycle after the access.
- R5: A hit on a MID-section rule raises its count by one and moves it to slot 0. The entries ahead of it shift up by one slot.
- R6: A hit on a NEW-section rule moves it to slot 0 with its count unchanged. The entries ahead of it shift up by one slot.
- R7: With the MID section present, a hit on an OLD-section rule leaves all slots, ids and counts unchanged.
- R8: A hit whose id is not resident changes nothing.
- R9: Counts saturate at 2^CNT_W-1 and are never zero in a valid slot.
- R10: With `HAS_MID`=0, the NEW tail moves directly into the OLD head on insertion. A hit on an OLD rule raises its count by one (saturating) without moving it.
- R11: With `accValid` low, no slot changes and `victimValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accHit | input | 1 | 1: matcher reports a cache hit, 0: miss, insert `accId` |
| accId | input | ID_W | Rule id of the access |
| slotValid | output | SLOTS | Per-slot occupancy, bit i for slot i |
| slotIds | output | SLOTS*ID_W | Rule id per slot |
| slotCnts | output | SLOTS*CNT_W | Reference count per slot |
| victimValid | output | 1 | One-cycle pulse: an entry was evicted |
| victimId | output | ID_W | Id of the evicted rule |

## Verification
The bench aims at eviction with equal counts across OLD, where a design that scanned the wrong way would evict the OLD head instead of the tail. It also covers hits on NEW slot 0 and on the MID tail. An off-by-one shift range there would duplicate an entry or drop a neighbour. Counts are driven past their limit: a missing saturation shows up as a wrap to zero, which then breaks victim choice. Both section layouts run the same stimulus, so a variant that still treated OLD hits as no-ops, or that left a phantom MID, would show up in its slot contents.

// File: rtl/frc_pkg.sv
package frc_pkg;

  // Update strobes sent from control to the slot store.
  typedef struct packed {
    logic shiftEn;  // write front entry into slot 0, shift slots below the hole
    logic bumpEn;   // saturating count increment of one slot, in place
  } frc_strobe_t;

endpackage

// File: rtl/frc_min_pick.sv
module frc_min_pick #(
  parameter int OLD_SZ = 3,
  parameter int CNT_W  = 4,
  localparam int IW    = $clog2(OLD_SZ + 1)
) (
  input  logic [OLD_SZ*CNT_W-1:0] oldCnts,
  output logic [IW-1:0]           pickIdx
);

  logic [CNT_W-1:0] bestCnt;

  // Scan from the OLD head to the tail; "<=" lets later (tail-side) equals win.
  always_comb begin
    pickIdx = '0;
    bestCnt = oldCnts[CNT_W-1:0];
    for (int j = 1; j < OLD_SZ; j++) begin
      if (oldCnts[j*CNT_W +: CNT_W] <= bestCnt) begin
        bestCnt = oldCnts[j*CNT_W +: CNT_W];
        pickIdx = IW'(j);
      end
    end
  end

endmodule

// File: rtl/frc_ctrl.sv
module frc_ctrl
  import frc_pkg::*;
#(
  parameter int NEW_SZ  = 3,
  parameter int MID_EFF = 3,
  parameter int OLD_SZ  = 3,
  parameter int ID_W    = 8,
  parameter int CNT_W   = 4,
  parameter bit HAS_MID = 1'b1,
  localparam int SLOTS  = NEW_SZ + MID_EFF + OLD_SZ,
  localparam int PW     = $clog2(SLOTS + 1),
  localparam int IW     = $clog2(OLD_SZ + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accValid,
  input  logic                   accHit,
  input  logic [ID_W-1:0]        accId,
  input  logic [SLOTS-1:0]       entValid,
  input  logic [SLOTS*ID_W-1:0]  entIds,
  input  logic [SLOTS*CNT_W-1:0] entCnts,
  output frc_strobe_t            strobe,
  output logic [PW-1:0]          holePos,
  output logic [PW-1:0]          bumpPos,
  output logic [ID_W-1:0]        frontId,
  output logic [CNT_W-1:0]       frontCnt,
  output logic                   victimValid,
  output logic [ID_W-1:0]        victimId
);

  localparam int OLD_BASE = NEW_SZ + MID_EFF;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [SLOTS-1:0] matchVec;
  logic             hitFound;
  logic [PW-1:0]    hitPos;
  logic [PW-1:0]    fillCnt;
  logic             isFull;
  logic             inNew;
  logic             inMid;
  logic [CNT_W-1:0] hitCnt;
  logic [IW-1:0]    pickIdx;
  logic [PW-1:0]    victimPos;
  logic [ID_W-1:0]  evictId;
  logic             doEvict;

  for (genvar i = 0; i < SLOTS; i++) begin : g_match
    assign matchVec[i] = entValid[i] && (entIds[i*ID_W +: ID_W] == accId);
  end

  always_comb begin
    hitFound = 1'b0;
    hitPos   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitFound = 1'b1;
        hitPos   = PW'(i);
      end
    end
  end

  always_comb begin
    fillCnt = '0;
    for (int i = 0; i < SLOTS; i++) fillCnt = fillCnt + PW'(entValid[i]);
  end

  assign isFull = (fillCnt == PW'(SLOTS));
  assign inNew  = (hitPos < PW'(NEW_SZ));
  assign inMid  = !inNew && (hitPos < PW'(OLD_BASE));
  assign hitCnt = entCnts[int'(hitPos)*CNT_W +: CNT_W];

  frc_min_pick #(
    .OLD_SZ(OLD_SZ),
    .CNT_W (CNT_W)
  ) u_pick (
    .oldCnts(entCnts[SLOTS*CNT_W-1 : OLD_BASE*CNT_W]),
    .pickIdx(pickIdx)
  );

  assign victimPos = PW'(OLD_BASE) + PW'(pickIdx);
  assign evictId   = entIds[int'(victimPos)*ID_W +: ID_W];
  assign doEvict   = accValid && !accHit && isFull;

  always_comb begin
    strobe   = '0;
    holePos  = '0;
    bumpPos  = hitPos;
    frontId  = accId;
    frontCnt = CNT_W'(1);
    if (accValid) begin
      if (!accHit) begin
        strobe.shiftEn = 1'b1;
        holePos        = isFull ? victimPos : fillCnt;
      end else if (hitFound) begin
        if (inNew) begin
          strobe.shiftEn = 1'b1;
          holePos        = hitPos;
          frontCnt       = hitCnt;
        end else if (inMid) begin
          strobe.shiftEn = 1'b1;
          holePos        = hitPos;
          frontCnt       = (hitCnt == CMAX) ? hitCnt : hitCnt + 1'b1;
        end else if (!HAS_MID) begin
          strobe.bumpEn = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimId    <= '0;
    end else begin
      victimValid <= doEvict;
      if (doEvict) victimId <= evictId;
    end
  end

  // R5: a MID hit lands at the head with a live count
  p_mid_front_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accHit && hitFound && inMid) |=>
      (entValid[0] && entIds[ID_W-1:0] == $past(accId) && entCnts[CNT_W-1:0] != '0));

  // R7: with MID present, an OLD hit is a no-op on the slots
  p_old_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_MID && accValid && accHit && hitFound && !inNew && !inMid) |=>
      ($stable(entValid) && $stable(entIds) && $stable(entCnts)));

  // R8: hit on an absent id changes nothing
  p_absent_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accHit && !hitFound) |=>
      ($stable(entValid) && $stable(entIds) && $stable(entCnts)));

  // R11: idle cycle keeps state and raises no victim
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> ($stable(entValid) && $stable(entIds) && $stable(entCnts) && !victimValid));

endmodule

// File: rtl/frc_store.sv
module frc_store
  import frc_pkg::*;
#(
  parameter int SLOTS = 9,
  parameter int ID_W  = 8,
  parameter int CNT_W = 4,
  localparam int PW   = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  frc_strobe_t            strobe,
  input  logic [PW-1:0]          holePos,
  input  logic [PW-1:0]          bumpPos,
  input  logic [ID_W-1:0]        frontId,
  input  logic [CNT_W-1:0]       frontCnt,
  output logic [SLOTS-1:0]       entValid,
  output logic [SLOTS*ID_W-1:0]  entIds,
  output logic [SLOTS*CNT_W-1:0] entCnts
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             vQ  [SLOTS];
  logic [ID_W-1:0]  idQ [SLOTS];
  logic [CNT_W-1:0] cQ  [SLOTS];
  logic             vN  [SLOTS];
  logic [ID_W-1:0]  idN [SLOTS];
  logic [CNT_W-1:0] cN  [SLOTS];

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      vN[i]  = vQ[i];
      idN[i] = idQ[i];
      cN[i]  = cQ[i];
    end
    if (strobe.shiftEn) begin
      for (int i = SLOTS - 1; i > 0; i--) begin
        if (i <= int'(holePos)) begin
          vN[i]  = vQ[i-1];
          idN[i] = idQ[i-1];
          cN[i]  = cQ[i-1];
        end
      end
      vN[0]  = 1'b1;
      idN[0] = frontId;
      cN[0]  = frontCnt;
    end else if (strobe.bumpEn && int'(bumpPos) < SLOTS) begin
      if (cQ[int'(bumpPos)] != CMAX) cN[int'(bumpPos)] = cQ[int'(bumpPos)] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        vQ[i]  <= 1'b0;
        idQ[i] <= '0;
        cQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        vQ[i]  <= vN[i];
        idQ[i] <= idN[i];
        cQ[i]  <= cN[i];
      end
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_out
    assign entValid[i]                 = vQ[i];
    assign entIds[i*ID_W +: ID_W]      = idQ[i];
    assign entCnts[i*CNT_W +: CNT_W]   = cQ[i];

    // R9: an occupied slot never carries a zero count
    p_cnt_live_r9: assert property (@(posedge clk) disable iff (!rstN)
      vQ[i] |-> (cQ[i] != '0));

    if (i > 0) begin : g_pack
      // R3: occupancy is a contiguous run from slot 0
      p_packed_r3: assert property (@(posedge clk) disable iff (!rstN)
        vQ[i] |-> vQ[i-1]);
    end
  end

endmodule

// File: rtl/freq_rule_cache.sv
module freq_rule_cache
  import frc_pkg::*;
#(
  parameter int NEW_SZ  = 3,
  parameter int MID_SZ  = 3,
  parameter int OLD_SZ  = 3,
  parameter int ID_W    = 8,
  parameter int CNT_W   = 4,
  parameter bit HAS_MID = 1'b1,
  localparam int MID_EFF = HAS_MID ? MID_SZ : 0,
  localparam int SLOTS   = NEW_SZ + MID_EFF + OLD_SZ
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accValid,
  input  logic                   accHit,
  input  logic [ID_W-1:0]        accId,
  output logic [SLOTS-1:0]       slotValid,
  output logic [SLOTS*ID_W-1:0]  slotIds,
  output logic [SLOTS*CNT_W-1:0] slotCnts,
  output logic                   victimValid,
  output logic [ID_W-1:0]        victimId
);

  localparam int PW = $clog2(SLOTS + 1);

  frc_strobe_t      strobe;
  logic [PW-1:0]    holePos;
  logic [PW-1:0]    bumpPos;
  logic [ID_W-1:0]  frontId;
  logic [CNT_W-1:0] frontCnt;

  frc_ctrl #(
    .NEW_SZ (NEW_SZ),
    .MID_EFF(MID_EFF),
    .OLD_SZ (OLD_SZ),
    .ID_W   (ID_W),
    .CNT_W  (CNT_W),
    .HAS_MID(HAS_MID)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .accHit     (accHit),
    .accId      (accId),
    .entValid   (slotValid),
    .entIds     (slotIds),
    .entCnts    (slotCnts),
    .strobe     (strobe),
    .holePos    (holePos),
    .bumpPos    (bumpPos),
    .frontId    (frontId),
    .frontCnt   (frontCnt),
    .victimValid(victimValid),
    .victimId   (victimId)
  );

  frc_store #(
    .SLOTS(SLOTS),
    .ID_W (ID_W),
    .CNT_W(CNT_W)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .holePos (holePos),
    .bumpPos (bumpPos),
    .frontId (frontId),
    .frontCnt(frontCnt),
    .entValid(slotValid),
    .entIds  (slotIds),
    .entCnts (slotCnts)
  );

  // R2: a miss places the id at the NEW head with count 1
  p_insert_head_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accHit) |=>
      (slotValid[0] && slotIds[ID_W-1:0] == $past(accId) && slotCnts[CNT_W-1:0] == CNT_W'(1)));

  // R4: a victim is only reported after a miss on a full cache
  p_victim_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> $past(accValid && !accHit && (&slotValid)));

endmodule

// File: tb/freq_rule_cache_bench.sv
module freq_rule_cache_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic accHit = 1'b0;
  logic [7:0] accId = '0;

  logic [8:0]  aValid;
  logic [71:0] aIds;
  logic [35:0] aCnts;
  logic        aVicV;
  logic [7:0]  aVicId;
  logic [5:0]  bValid;
  logic [47:0] bIds;
  logic [23:0] bCnts;
  logic        bVicV;
  logic [7:0]  bVicId;

  int testsRun = 0;
  int testsFailed = 0;
  int nextId = 1;

  // Reference state per layout: k=0 with MID (9 slots), k=1 without (6 slots)
  int mV  [2][9];
  int mId [2][9];
  int mC  [2][9];

  always #5 clk = ~clk;

  freq_rule_cache u_freq_rule_cache (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit), .accId(accId),
    .slotValid(aValid), .slotIds(aIds), .slotCnts(aCnts),
    .victimValid(aVicV), .victimId(aVicId)
  );

  freq_rule_cache #(.HAS_MID(1'b0)) u_freq_rule_cache_nomid (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit), .accId(accId),
    .slotValid(bValid), .slotIds(bIds), .slotCnts(bCnts),
    .victimValid(bVicV), .victimId(bVicId)
  );

  function automatic int slotsOf(int k); return (k == 0) ? 9 : 6; endfunction
  function automatic int midOf(int k);   return (k == 0) ? 3 : 0; endfunction
  function automatic int satUp(int c);   return (c >= 15) ? 15 : c + 1; endfunction

  function automatic int findId(int k, int id);
    for (int i = 0; i < slotsOf(k); i++)
      if (mV[k][i] != 0 && mId[k][i] == id) return i;
    return -1;
  endfunction

  function automatic int dutValid(int k, int i);
    return (k == 0) ? int'(aValid[i]) : int'(bValid[i]);
  endfunction
  function automatic int dutId(int k, int i);
    return (k == 0) ? int'(aIds[i*8 +: 8]) : int'(bIds[i*8 +: 8]);
  endfunction
  function automatic int dutCnt(int k, int i);
    return (k == 0) ? int'(aCnts[i*4 +: 4]) : int'(bCnts[i*4 +: 4]);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic moveFront(int k, int hole, int id, int cnt);
    for (int i = hole; i > 0; i--) begin
      mV[k][i] = mV[k][i-1]; mId[k][i] = mId[k][i-1]; mC[k][i] = mC[k][i-1];
    end
    mV[k][0] = 1; mId[k][0] = id; mC[k][0] = cnt;
  endtask

  task automatic modelStep(int k, bit v, bit h, int id,
                           output string tag, output bit evV, output int evId);
    int n; int fill; int pos; int oldBase; int best;
    n = slotsOf(k); oldBase = 3 + midOf(k); evV = 0; evId = 0; fill = 0;
    tag = "R11";
    if (!v) return;
    for (int i = 0; i < n; i++) fill += mV[k][i];
    pos = findId(k, id);
    if (!h) begin
      if (fill == n) begin
        best = oldBase;
        for (int i = oldBase; i < n; i++) if (mC[k][i] <= mC[k][best]) best = i;
        evV = 1; evId = mId[k][best]; tag = "R4";
        moveFront(k, best, id, 1);
      end else begin
        tag = "R3";
        moveFront(k, fill, id, 1);
      end
    end else if (pos < 0) begin
      tag = "R8";
    end else if (pos < 3) begin
      tag = "R6";
      moveFront(k, pos, id, mC[k][pos]);
    end else if (pos < oldBase) begin
      tag = "R5";
      moveFront(k, pos, id, satUp(mC[k][pos]));
    end else if (midOf(k) == 0) begin
      tag = "R10";
      mC[k][pos] = satUp(mC[k][pos]);
    end else begin
      tag = "R7";
    end
  endtask

  task automatic compareDut(int k, string tag, bit evV, int evId);
    bit ok; int badPos; int act; int exp;
    ok = 1; badPos = -1; act = 0; exp = 0;
    for (int i = 0; i < slotsOf(k); i++) begin
      if (ok) begin
        if (dutValid(k, i) != mV[k][i]) begin
          ok = 0; badPos = i; act = dutValid(k, i); exp = mV[k][i];
        end else if (mV[k][i] != 0 && dutId(k, i) != mId[k][i]) begin
          ok = 0; badPos = i; act = dutId(k, i); exp = mId[k][i];
        end else if (mV[k][i] != 0 && dutCnt(k, i) != mC[k][i]) begin
          ok = 0; badPos = i; act = dutCnt(k, i); exp = mC[k][i];
        end
      end
    end
    check(ok, tag, $sformatf("layout %0d slot %0d contents", k, badPos), act, exp);
    act = (k == 0) ? int'(aVicV) : int'(bVicV);
    check(act == int'(evV), tag, $sformatf("layout %0d victimValid", k), act, int'(evV));
    if (evV) begin
      act = (k == 0) ? int'(aVicId) : int'(bVicId);
      check(act == evId, tag, $sformatf("layout %0d victimId", k), act, evId);
    end
  endtask

  // Called at a falling edge; returns at the following falling edge.
  task automatic step(bit v, bit h, int id);
    string t0, t1; bit e0, e1; int i0, i1;
    accValid = v; accHit = h; accId = 8'(id);
    modelStep(0, v, h, id, t0, e0, i0);
    modelStep(1, v, h, id, t1, e1, i1);
    @(posedge clk); @(negedge clk);
    accValid = 1'b0; accHit = 1'b0;
    compareDut(0, t0, e0, i0);
    compareDut(1, t1, e1, i1);
  endtask

  function automatic int freshId();
    int id;
    id = nextId;
    while (id == 0 || findId(0, id) >= 0 || findId(1, id) >= 0) id = (id + 1) % 256;
    nextId = (id + 1) % 256;
    return id;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 9; i++) begin mV[k][i] = 0; mId[k][i] = 0; mC[k][i] = 0; end
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(aValid == '0 && bValid == '0, "R1", "slots empty after reset",
          int'(aValid) | int'(bValid), 0);
    check(!aVicV && !bVicV, "R1", "no victim after reset", int'(aVicV) | int'(bVicV), 0);
  endtask

  initial begin
    #(200000 * 10);
    testsFailed++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int r; int pick; int xId; int xp;
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();

    // R2 / R10: ordered fill, section spill
    for (int id = 11; id <= 14; id++) step(1'b1, 1'b0, id);
    check(dutId(0, 0) == 14 && dutCnt(0, 0) == 1, "R2", "NEW head after 4 misses",
          dutId(0, 0), 14);
    check(dutId(0, 3) == 11, "R2", "MID head takes NEW tail", dutId(0, 3), 11);
    check(dutId(1, 3) == 11, "R10", "OLD head takes NEW tail without MID", dutId(1, 3), 11);

    // R4: equal counts, victim is the OLD tail
    for (int id = 15; id <= 17; id++) step(1'b1, 1'b0, id);
    check(bVicV && bVicId == 8'd11, "R4", "tie victim without MID", int'(bVicId), 11);
    for (int id = 18; id <= 20; id++) step(1'b1, 1'b0, id);
    check(aVicV && aVicId == 8'd11, "R4", "tie victim with MID", int'(aVicId), 11);

    // R6: hit at NEW head and NEW tail; R5: MID tail hit; R7/R8/R11
    step(1'b1, 1'b1, mId[0][0]);
    step(1'b1, 1'b1, mId[0][2]);
    step(1'b1, 1'b1, mId[0][5]);
    check(dutCnt(0, 0) == 2, "R5", "MID hit raises count", dutCnt(0, 0), 2);
    step(1'b1, 1'b1, mId[0][8]);
    step(1'b1, 1'b1, 200);
    step(1'b0, 1'b0, 0);

    // R9: keep hitting one rule whenever it sits in MID until it saturates
    xId = mId[0][0];
    nextId = 21;
    for (int it = 0; it < 120; it++) begin
      xp = findId(0, xId);
      if (xp >= 3 && xp < 6) step(1'b1, 1'b1, xId);
      else step(1'b1, 1'b1, mId[0][3]);
    end
    xp = findId(0, xId);
    check(xp >= 0 && dutCnt(0, (xp < 0) ? 0 : xp) == 15, "R9", "count saturates with MID",
          (xp < 0) ? -1 : dutCnt(0, xp), 15);

    // R10 / R9: OLD hits without MID count up in place and saturate
    xId = mId[1][5];
    for (int it = 0; it < 20; it++) step(1'b1, 1'b1, xId);
    check(dutId(1, 5) == xId && dutCnt(1, 5) == 15, "R10", "OLD hit count in place",
          dutCnt(1, 5), 15);

    // Random mix, checked against the model each cycle
    doReset();
    for (int it = 0; it < 4000; it++) begin
      r = int'($urandom_range(99));
      if (r < 40 || mV[0][0] == 0) begin
        step(1'b1, 1'b0, freshId());
      end else if (r < 90) begin
        pick = int'($urandom_range(8));
        while (mV[0][pick] == 0) pick--;
        step(1'b1, 1'b1, mId[0][pick]);
      end else if (r < 95) begin
        step(1'b1, 1'b1, freshId());
      end else begin
        step(1'b0, r[0], int'($urandom_range(255)));
      end
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule